// File: doc/BRIEF.md
# Reset-Sampled Strap Configuration Latch

This block reads a handful of board strap inputs while the chip-level reset line is high and freezes them when that line falls. From the frozen levels it derives the 12-bit I/O location of the configuration command port, a flag that tells whether that location is the standard-compatible one, the function of a shared output pin, and which of two function sets a group of CD-ROM interface pins uses. A volume-control enable bit from the hardware configuration data overrides the strap choice for the shared pin at any time. Two general-purpose control bits from a codec register drive their pins directly.

The reset line doubles as the block's synchronous active-high reset. Strap inputs pass through a synchronizer. While reset is high, the capture register keeps loading from the synchronizer output, so what it holds after reset falls is the last level sampled before the fall. All outputs are registered. While reset is high they show fixed defaults. From the first clock edge with reset low they show the decoded configuration.

Top module: `strap_cfg_latch`

## Requirements
- R1: Strap levels are captured only while `rst` is high, and the value held is the last one sampled before `rst` falls. Strap changes while `rst` is low have no effect on any output until the next reset.
- R2: With the port-select strap captured high, `cfg_port` is 0x279 whatever level the alternate strap has.
- R3: With the port-select strap captured low, `cfg_port` is 0x308 if the alternate strap was high and 0x388 if it was low.
- R4: `port_std` is 1 exactly when `cfg_port` is 0x279, and 0 for either moved location.
- R5: With `vcen` low, a high serial-data strap gives `shared_fn` = 0 (general-purpose) with `shared_pin` = `gpctl[1]`. A low serial-data strap gives `shared_fn` = 1 (chip-select) with `shared_pin` = `aux_cs_in`.
- R6: With `vcen` high, `shared_fn` = 2 (volume-down) and `shared_pin` = `voldn_in`, whatever the serial-data strap is. `vcen` acts at any time after reset, without a new reset.
- R7: `gp0_pin` follows `gpctl[0]` after reset.
- R8: `cd_primary` is 1 when the master-clock strap was captured high and 0 when it was captured low.
- R9: While `rst` is high the outputs show `cfg_port` = 0x279, `port_std` = 1, `shared_fn` = 0, `shared_pin` = 0, `gp0_pin` = 0 and `cd_primary` = 1.
- R10: `vcen`, `gpctl`, `aux_cs_in` and `voldn_in` reach the outputs one clock edge after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Chip reset line, active high, synchronous; its fall freezes the straps |
| strap_port_sel | input | 1 | Address-port select strap, high = standard location |
| strap_port_alt | input | 1 | Secondary select strap for the moved location |
| strap_sdata | input | 1 | Serial-data-out strap, selects the shared pin function |
| strap_mclk | input | 1 | Master-clock strap, selects the CD-ROM pin function set |
| vcen | input | 1 | Volume-control enable from hardware configuration data |
| gpctl | input | 2 | General-purpose control bits from the codec register |
| aux_cs_in | input | 1 | Auxiliary chip-select from the bus decoder |
| voldn_in | input | 1 | Volume-down signal |
| cfg_port | output | 12 | Configuration command port location |
| port_std | output | 1 | High when the port is at the standard location |
| shared_fn | output | 2 | Shared pin function: 0 general-purpose, 1 chip-select, 2 volume-down |
| shared_pin | output | 1 | Value driven on the shared pin |
| gp0_pin | output | 1 | General-purpose output 0 |
| cd_primary | output | 1 | CD-ROM pin function set, 1 = primary |

## Verification
A corrupted capture register shows as a wrong port location, a wrong compliance flag or a wrong pin function on the first clock edge after reset falls. It stays wrong until the next reset, so each captured strap combination is checked once, right after release. A capture register that keeps loading after release shows only once the straps move, so the straps are changed with reset low and the outputs checked again several cycles later. Errors in the live path show one edge after `vcen` or the control bits change.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  typedef enum logic [1:0] {
    FN_GPIO  = 2'd0,
    FN_CSEL  = 2'd1,
    FN_VOLDN = 2'd2
  } pin_fn_e;

  typedef struct packed {
    logic port_sel;
    logic port_alt;
    logic sd_strap;
    logic clk_strap;
  } strap_t;

  localparam int STRAP_W = $bits(strap_t);
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) stage_q[s] <= d;
    end else begin : g_rest
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] cap_q = '1;

  always_ff @(posedge clk) begin
    if (rst) cap_q <= d;
  end

  assign q = cap_q;

  AST_HOLD_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(cap_q)) else $error("capture moved"); // R1
endmodule

// File: rtl/port_decode.sv
module port_decode #(
  parameter int          PORT_W   = 12,
  parameter logic [11:0] PORT_STD = 12'h279,
  parameter logic [11:0] PORT_HI  = 12'h308,
  parameter logic [11:0] PORT_LO  = 12'h388
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_sel,
  input  logic              port_alt,
  output logic [PORT_W-1:0] port_q,
  output logic              std_q
);
  logic [PORT_W-1:0] port_d;

  always_comb begin
    if (port_sel)      port_d = PORT_W'(PORT_STD);
    else if (port_alt) port_d = PORT_W'(PORT_HI);
    else               port_d = PORT_W'(PORT_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_q <= PORT_W'(PORT_STD);
      std_q  <= 1'b1;
    end else begin
      port_q <= port_d;
      std_q  <= port_sel;
    end
  end

  AST_PORT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (port_q == PORT_W'(PORT_STD) || port_q == PORT_W'(PORT_HI)
                     || port_q == PORT_W'(PORT_LO))) else $error("bad port"); // R3
  AST_STD_WINS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(port_sel)) |-> port_q == PORT_W'(PORT_STD))
    else $error("std port"); // R2
endmodule

// File: rtl/pin_mux.sv
module pin_mux
  import strap_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sd_strap,
  input  logic       clk_strap,
  input  logic       vcen,
  input  logic [1:0] gpctl,
  input  logic       aux_cs_in,
  input  logic       voldn_in,
  output pin_fn_e    fn_q,
  output logic       pin_q,
  output logic       gp0_q,
  output logic       cdp_q
);
  pin_fn_e fn_d;
  logic    pin_d;

  always_comb begin
    if (vcen)          fn_d = FN_VOLDN;
    else if (sd_strap) fn_d = FN_GPIO;
    else               fn_d = FN_CSEL;
    unique case (fn_d)
      FN_VOLDN: pin_d = voldn_in;
      FN_CSEL:  pin_d = aux_cs_in;
      default:  pin_d = gpctl[1];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q  <= FN_GPIO;
      pin_q <= 1'b0;
      gp0_q <= 1'b0;
      cdp_q <= 1'b1;
    end else begin
      fn_q  <= fn_d;
      pin_q <= pin_d;
      gp0_q <= gpctl[0];
      cdp_q <= clk_strap;
    end
  end

  AST_VCEN_OVERRIDE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(vcen)) |-> (fn_q == FN_VOLDN && pin_q == $past(voldn_in)))
    else $error("vcen override"); // R6
  AST_FN_CODE: assert property (@(posedge clk) disable iff (rst)
    fn_q != pin_fn_e'(2'd3)) else $error("fn code"); // R5
  AST_GPIO_PATH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && fn_q == FN_GPIO) |-> pin_q == $past(gpctl[1]))
    else $error("gpio path"); // R5
endmodule

// File: rtl/strap_cfg_latch.sv
module strap_cfg_latch
  import strap_cfg_pkg::*;
#(
  parameter int          PORT_W      = 12,
  parameter int          SYNC_STAGES = 2,
  parameter logic [11:0] PORT_STD    = 12'h279,
  parameter logic [11:0] PORT_HI     = 12'h308,
  parameter logic [11:0] PORT_LO     = 12'h388
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_port_sel,
  input  logic              strap_port_alt,
  input  logic              strap_sdata,
  input  logic              strap_mclk,
  input  logic              vcen,
  input  logic [1:0]        gpctl,
  input  logic              aux_cs_in,
  input  logic              voldn_in,
  output logic [PORT_W-1:0] cfg_port,
  output logic              port_std,
  output logic [1:0]        shared_fn,
  output logic              shared_pin,
  output logic              gp0_pin,
  output logic              cd_primary
);
  strap_t  raw, synced, held;
  pin_fn_e fn;

  assign raw = '{port_sel: strap_port_sel, port_alt: strap_port_alt,
                 sd_strap: strap_sdata, clk_strap: strap_mclk};

  strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .d(raw), .q(synced));

  strap_capture #(.WIDTH(STRAP_W)) i_capture (
    .clk(clk), .rst(rst), .d(synced), .q(held));

  port_decode #(.PORT_W(PORT_W), .PORT_STD(PORT_STD), .PORT_HI(PORT_HI),
                .PORT_LO(PORT_LO)) i_decode (
    .clk(clk), .rst(rst), .port_sel(held.port_sel), .port_alt(held.port_alt),
    .port_q(cfg_port), .std_q(port_std));

  pin_mux i_mux (
    .clk(clk), .rst(rst), .sd_strap(held.sd_strap), .clk_strap(held.clk_strap),
    .vcen(vcen), .gpctl(gpctl), .aux_cs_in(aux_cs_in), .voldn_in(voldn_in),
    .fn_q(fn), .pin_q(shared_pin), .gp0_q(gp0_pin), .cdp_q(cd_primary));

  assign shared_fn = fn;

  AST_STD_FLAG: assert property (@(posedge clk) disable iff (rst)
    port_std == (cfg_port == PORT_W'(PORT_STD))) else $error("std flag"); // R4
  AST_RESET_VIEW: assert property (@(posedge clk)
    $past(rst) |-> (port_std && shared_fn == 2'd0 && cd_primary))
    else $error("reset view"); // R9
endmodule

// File: tb/test_strap_cfg_latch.sv
module test_strap_cfg_latch;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {sel,alt,sd,mclk,vcen,gp1,gp0,aux,vdn, port[11:0],std,fn[1:0],pin,gp0,cdp}
  localparam logic [26:0] VEC [NV] = '{
    {9'b1_1_1_1_0_1_0_0_0, 12'h279, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1},
    {9'b0_1_1_0_0_0_1_1_0, 12'h308, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0},
    {9'b0_0_0_1_0_1_1_0_0, 12'h388, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1},
    {9'b0_0_0_0_0_0_0_1_1, 12'h388, 1'b0, 2'd1, 1'b1, 1'b0, 1'b0},
    {9'b1_0_0_1_1_1_0_1_0, 12'h279, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1},
    {9'b0_1_1_1_1_0_1_0_1, 12'h308, 1'b0, 2'd2, 1'b1, 1'b1, 1'b1},
    {9'b1_1_0_0_0_0_1_1_1, 12'h279, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0},
    {9'b0_1_0_1_0_1_0_0_1, 12'h308, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic s_sel = 1'b1, s_alt = 1'b1, s_sd = 1'b1, s_mclk = 1'b1;
  logic vcen = 1'b0, aux = 1'b0, vdn = 1'b0;
  logic [1:0] gp = 2'b00;
  logic [11:0] cfg_port;
  logic port_std, shared_pin, gp0_pin, cd_primary;
  logic [1:0] shared_fn;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_cfg_latch i_strap_cfg_latch (
    .clk(clk), .rst(rst), .strap_port_sel(s_sel), .strap_port_alt(s_alt),
    .strap_sdata(s_sd), .strap_mclk(s_mclk), .vcen(vcen), .gpctl(gp),
    .aux_cs_in(aux), .voldn_in(vdn), .cfg_port(cfg_port), .port_std(port_std),
    .shared_fn(shared_fn), .shared_pin(shared_pin), .gp0_pin(gp0_pin),
    .cd_primary(cd_primary));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag, input logic [17:0] e);
    chk({tag, " R2 R3 port"}, cfg_port, e[17:6]);
    chk({tag, " R4 std"}, port_std, e[5]);
    chk({tag, " R5 R6 fn"}, shared_fn, e[4:3]);
    chk({tag, " R5 R6 pin"}, shared_pin, e[2]);
    chk({tag, " R7 gp0"}, gp0_pin, e[1]);
    chk({tag, " R8 cd"}, cd_primary, e[0]);
  endtask

  initial begin
    cyc(8);
    // R9: defaults while reset is high, whatever the straps and live inputs
    s_sel = 0; s_alt = 0; s_sd = 0; s_mclk = 0; vcen = 1; gp = 2'b11; vdn = 1;
    cyc(6);
    check_all("R9 reset", {12'h279, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      rst = 1;
      {s_sel, s_alt, s_sd, s_mclk, vcen, gp[1], gp[0], aux, vdn} = VEC[i][26:18];
      cyc(6);
      rst = 0;
      cyc(2);
      check_all($sformatf("vec%0d", i), VEC[i][17:0]);
    end

    // R1: strap changes with reset low are ignored
    s_sel = ~s_sel; s_alt = ~s_alt; s_sd = ~s_sd; s_mclk = ~s_mclk;
    cyc(8);
    check_all("R1 hold", VEC[NV-1][17:0]);

    // R6 and R10: vcen live, one edge to reach the outputs
    vcen = 1; vdn = 1;
    @(posedge clk); #1;
    chk("R10 latency fn", shared_fn, 2'd2);
    chk("R6 live pin", shared_pin, 1);
    cyc(1);
    vcen = 0; aux = 1;
    cyc(1);
    chk("R6 release fn R5", shared_fn, 2'd1);
    chk("R5 csel pin", shared_pin, 1);

    // R7 and R10: gp0 follows gpctl[0]
    gp[0] = 1; cyc(1);
    chk("R7 gp0 high", gp0_pin, 1);
    gp[0] = 0; cyc(1);
    chk("R7 gp0 low", gp0_pin, 0);

    // R1: a new reset recaptures the straps now on the pins
    // straps now: sel=1 alt=0 sd=1 mclk=0
    rst = 1; cyc(6); rst = 0; gp = 2'b10; cyc(2);
    check_all("R1 recapture", {12'h279, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0});
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hang expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule